// File: doc/BRIEF.md
# Bridge Configuration Request Router

This block sits at the downstream entry of a bridge from a host link to a PCI-X bus. It takes one request at a time and decides whether to accept it and where to send it. Each request carries an address, a kind code, a direction flag and a broadcast flag. For configuration requests, it compares the bus number in the address with the programmed secondary and subordinate bus numbers. From that comparison it builds one of two forms. A request for the bus directly below the bridge becomes a Type 0 cycle that drives the IDSEL line of the target device. A request for a bus further downstream leaves as a Type 1 cycle.

Requests that land in the fixed interrupt address window are accepted only if they are broadcast End-of-Interrupt messages, and these go to the interrupt controller port. Every other request comes out marked as rejected, with a reason code and without a target. A valid/ready handshake at each side and one register stage give a decode latency of one cycle.

Top module: `cfg_req_router`

## Requirements
- R1: A request taken on a cycle with `req_valid_i` and `req_ready_o` both high appears on the outputs after the next rising clock edge. While `out_valid_o` is high and `out_ready_i` is low, all outputs hold their values and `req_ready_o` is low.
- R2: A configuration request has kind 0. Its bus number is `req_addr_i[23:16]` and its device number is `[15:11]`. When the bus number equals the secondary bus number and lies in range, the output carries target 1 (PCI-X) and `out_type1_o`=0. Its address has bit 16+device set and every other bit of `[31:16]` clear. Bits `[15:11]` are clear, bits `[10:2]` are copied from the request and bits `[1:0]` are 00.
- R3: A configuration request whose bus number is above the secondary number and at most the subordinate number goes out with target 1 and `out_type1_o`=1. Its address is `{8'h00, req_addr_i[23:2], 2'b01}`. Only the bus check applies to kind 0, so the upper address bits play no part.
- R4: A configuration request whose bus number is below the secondary number or above the subordinate number is rejected with reason 1. This covers any request when secondary is greater than subordinate.
- R5: A request for the secondary bus with a device number of 16 or more has no IDSEL line and is rejected with reason 2.
- R6: For accepted requests, `out_write_o` follows `req_write_i`: 0 for a configuration read, 1 for a configuration write.
- R7: A request of kind 1 (EOI) with `req_bcast_i`=1 and an address from 0xFD_F800_0000 to 0xFD_F8FF_FFFF inclusive goes out with target 2 (interrupt controller) and address `req_addr_i[31:0]`.
- R8: Inside that window, a request of any kind other than 0 or 1 is rejected with reason 3. An EOI with `req_bcast_i`=0 is rejected with reason 4.
- R9: A request of a kind other than 0 with an address outside the window is rejected with reason 5.
- R10: A rejected output has `out_reject_o`=1, target 0, `out_type1_o`=0, `out_write_o`=0 and address 0. An accepted output has `out_reject_o`=0 and reason 0.
- R11: While `rst_ni` is low, `out_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_kind_i | input | 2 | 0 config, 1 EOI, 2/3 other |
| req_addr_i | input | 40 | Request address |
| req_write_i | input | 1 | Direction, 1 = write |
| req_bcast_i | input | 1 | Broadcast flag |
| sec_bus_i | input | 8 | Secondary bus number |
| sub_bus_i | input | 8 | Subordinate bus number |
| out_valid_o | output | 1 | Routed result present |
| out_ready_i | input | 1 | Consumer takes result |
| out_target_o | output | 2 | 0 none, 1 PCI-X, 2 interrupt controller |
| out_type1_o | output | 1 | PCI-X cycle is Type 1 |
| out_write_o | output | 1 | Configuration write |
| out_addr_o | output | 32 | Outgoing address |
| out_reject_o | output | 1 | Request refused |
| out_reason_o | output | 3 | Reject reason code |

## Verification
The assertions rely on a few properties of the inputs. The consumer may stall at any time. The bus-number registers and request fields may change freely between requests, but they are sampled only in the cycle a request is taken. Kind codes 2 and 3 must behave the same. The stimulus changes inputs only on falling edges and keeps the bus registers steady within each vector. It covers equal, inverted and boundary settings of the bus registers, and addresses one step inside and one step outside both ends of the interrupt window. It stalls the output for several cycles while a second request waits, to exercise the hold rule.

// File: rtl/cfg_rt_pkg.sv
package cfg_rt_pkg;
  localparam int AD_W = 32;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PCIX = 2'd1,
    TGT_INTC = 2'd2
  } tgt_e;

  localparam logic [1:0] KIND_CFG = 2'd0;
  localparam logic [1:0] KIND_EOI = 2'd1;

  localparam logic [2:0] RSN_NONE      = 3'd0;
  localparam logic [2:0] RSN_BUS_RANGE = 3'd1;
  localparam logic [2:0] RSN_NO_IDSEL  = 3'd2;
  localparam logic [2:0] RSN_WIN_KIND  = 3'd3;
  localparam logic [2:0] RSN_UNICAST   = 3'd4;
  localparam logic [2:0] RSN_NO_DECODE = 3'd5;

  typedef struct packed {
    tgt_e            tgt;
    logic            type1;
    logic            write;
    logic [AD_W-1:0] addr;
    logic            reject;
    logic [2:0]      reason;
  } route_t;
endpackage

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode
  import cfg_rt_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int IDSEL_LSB = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [23:0]      cfg_addr_i,
  input  logic             write_i,
  input  logic [BUS_W-1:0] sec_bus_i,
  input  logic [BUS_W-1:0] sub_bus_i,
  output route_t           route_o
);
  localparam int BUS_LSB   = 16;
  localparam int DEV_W     = 5;
  localparam int NUM_IDSEL = AD_W - IDSEL_LSB;
  localparam int GAP_W     = IDSEL_LSB - 11;
  localparam int T1_PAD    = AD_W - 24;

  logic [BUS_W-1:0]     bus;
  logic [DEV_W-1:0]     dev;
  logic                 in_range, is_local, dev_ok;
  logic [NUM_IDSEL-1:0] idsel;
  logic [1:0]           unused_lsb;

  assign bus        = cfg_addr_i[BUS_LSB +: BUS_W];
  assign dev        = cfg_addr_i[15:11];
  assign in_range   = (bus >= sec_bus_i) && (bus <= sub_bus_i);
  assign is_local   = (bus == sec_bus_i);
  assign dev_ok     = (int'(dev) < NUM_IDSEL);
  assign unused_lsb = cfg_addr_i[1:0];

  for (genvar g = 0; g < NUM_IDSEL; g++) begin : g_idsel
    assign idsel[g] = (int'(dev) == g);
  end

  always_comb begin
    route_o = '0;
    if (!in_range) begin
      route_o.reject = 1'b1;
      route_o.reason = RSN_BUS_RANGE;
    end else if (is_local && !dev_ok) begin
      route_o.reject = 1'b1;
      route_o.reason = RSN_NO_IDSEL;
    end else if (is_local) begin
      route_o.tgt   = TGT_PCIX;
      route_o.write = write_i;
      route_o.addr  = {idsel, {GAP_W{1'b0}}, cfg_addr_i[10:2], 2'b00};
    end else begin
      route_o.tgt   = TGT_PCIX;
      route_o.type1 = 1'b1;
      route_o.write = write_i;
      route_o.addr  = {{T1_PAD{1'b0}}, cfg_addr_i[23:2], 2'b01};
    end
  end

  // Type 0 drives exactly one IDSEL line
  assert_idsel_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o.tgt == TGT_PCIX && !route_o.type1) |-> $onehot(route_o.addr[AD_W-1:IDSEL_LSB]));
  // accepted bus lies within the programmed range
  assert_bus_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_o.reject |-> (bus >= sec_bus_i && bus <= sub_bus_i));
endmodule

// File: rtl/cfg_irq_filter.sv
module cfg_irq_filter
  import cfg_rt_pkg::*;
#(
  parameter int                ADDR_W   = 40,
  parameter logic [ADDR_W-1:0] IRQ_BASE = 40'hFD_F800_0000,
  parameter logic [ADDR_W-1:0] IRQ_LAST = 40'hFD_F8FF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        kind_i,
  input  logic              write_i,
  input  logic              bcast_i,
  output route_t            route_o
);
  logic in_win, is_eoi;

  assign in_win = (addr_i >= IRQ_BASE) && (addr_i <= IRQ_LAST);
  assign is_eoi = (kind_i == KIND_EOI);

  always_comb begin
    route_o = '0;
    if (!in_win) begin
      route_o.reject = 1'b1;
      route_o.reason = RSN_NO_DECODE;
    end else if (!is_eoi) begin
      route_o.reject = 1'b1;
      route_o.reason = RSN_WIN_KIND;
    end else if (!bcast_i) begin
      route_o.reject = 1'b1;
      route_o.reason = RSN_UNICAST;
    end else begin
      route_o.tgt   = TGT_INTC;
      route_o.write = write_i;
      route_o.addr  = addr_i[AD_W-1:0];
    end
  end

  // only broadcast EOIs reach the interrupt controller
  assert_intc_bcast_eoi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o.tgt == TGT_INTC) |-> (bcast_i && kind_i == KIND_EOI));
  assert_intc_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o.tgt == TGT_INTC) |-> (addr_i >= IRQ_BASE && addr_i <= IRQ_LAST));
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_rt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   in_valid_i,
  output logic   in_ready_o,
  input  route_t in_route_i,
  output logic   out_valid_o,
  input  logic   out_ready_i,
  output route_t out_route_o
);
  logic in_fire;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign in_fire    = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_route_o <= '0;
    end else if (in_fire) begin
      out_valid_o <= 1'b1;
      out_route_o <= in_route_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  assert_hold_on_stall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_route_o)));
  assert_no_take_on_stall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  assert_take_gives_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire |=> out_valid_o);
endmodule

// File: rtl/cfg_req_router.sv
module cfg_req_router
  import cfg_rt_pkg::*;
#(
  parameter int                ADDR_W    = 40,
  parameter int                BUS_W     = 8,
  parameter int                IDSEL_LSB = 16,
  parameter logic [ADDR_W-1:0] IRQ_BASE  = 40'hFD_F800_0000,
  parameter logic [ADDR_W-1:0] IRQ_LAST  = 40'hFD_F8FF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_bcast_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  input  logic [BUS_W-1:0]  sub_bus_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [1:0]        out_target_o,
  output logic              out_type1_o,
  output logic              out_write_o,
  output logic [AD_W-1:0]   out_addr_o,
  output logic              out_reject_o,
  output logic [2:0]        out_reason_o
);
  route_t cfg_route, irq_route, sel_route, reg_route;

  cfg_bus_decode #(.BUS_W(BUS_W), .IDSEL_LSB(IDSEL_LSB)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_addr_i (req_addr_i[23:0]),
    .write_i    (req_write_i),
    .sec_bus_i  (sec_bus_i),
    .sub_bus_i  (sub_bus_i),
    .route_o    (cfg_route)
  );

  cfg_irq_filter #(.ADDR_W(ADDR_W), .IRQ_BASE(IRQ_BASE), .IRQ_LAST(IRQ_LAST)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (req_addr_i),
    .kind_i  (req_kind_i),
    .write_i (req_write_i),
    .bcast_i (req_bcast_i),
    .route_o (irq_route)
  );

  assign sel_route = (req_kind_i == KIND_CFG) ? cfg_route : irq_route;

  cfg_out_stage u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_route_i  (sel_route),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_route_o (reg_route)
  );

  assign out_target_o = reg_route.tgt;
  assign out_type1_o  = reg_route.type1;
  assign out_write_o  = reg_route.write;
  assign out_addr_o   = reg_route.addr;
  assign out_reject_o = reg_route.reject;
  assign out_reason_o = reg_route.reason;

  assert_reject_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_reject_o) |-> (out_target_o == TGT_NONE && out_addr_o == '0 && !out_write_o));
  assert_accept_no_reason_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_reject_o) |-> (out_reason_o == RSN_NONE && out_target_o != TGT_NONE));
  assert_cfg_never_intc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_kind_i == KIND_CFG) |=> (out_target_o != TGT_INTC));
endmodule

// File: tb/tb_cfg_req_router.sv
`timescale 1ns/1ps
module tb_cfg_req_router;
  typedef struct packed {
    logic [1:0]  kind;
    logic [39:0] addr;
    logic        wr;
    logic        bc;
    logic [7:0]  sec;
    logic [7:0]  sub;
    logic [1:0]  tgt;
    logic        t1;
    logic        ew;
    logic [31:0] eaddr;
    logic        rej;
    logic [2:0]  rsn;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 40'h00_0004_1A14, 1'b0, 1'b0, 8'd4, 8'd7, 2'd1, 1'b0, 1'b0, 32'h0008_0214, 1'b0, 3'd0},
    '{2'd0, 40'h00_0004_0000, 1'b1, 1'b0, 8'd4, 8'd7, 2'd1, 1'b0, 1'b1, 32'h0001_0000, 1'b0, 3'd0},
    '{2'd0, 40'h00_0004_7FFC, 1'b0, 1'b0, 8'd4, 8'd7, 2'd1, 1'b0, 1'b0, 32'h8000_07FC, 1'b0, 3'd0},
    '{2'd0, 40'h00_0004_8000, 1'b0, 1'b0, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd2},
    '{2'd0, 40'h00_0005_1A14, 1'b0, 1'b0, 8'd4, 8'd7, 2'd1, 1'b1, 1'b0, 32'h0005_1A15, 1'b0, 3'd0},
    '{2'd0, 40'h00_0007_FFFC, 1'b1, 1'b0, 8'd4, 8'd7, 2'd1, 1'b1, 1'b1, 32'h0007_FFFD, 1'b0, 3'd0},
    '{2'd0, 40'h00_0008_0000, 1'b0, 1'b0, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd1},
    '{2'd0, 40'h00_0003_0000, 1'b1, 1'b0, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd1},
    '{2'd0, 40'h00_0005_0000, 1'b0, 1'b0, 8'd4, 8'd4, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd1},
    '{2'd0, 40'h00_0004_0800, 1'b0, 1'b0, 8'd4, 8'd4, 2'd1, 1'b0, 1'b0, 32'h0002_0000, 1'b0, 3'd0},
    '{2'd0, 40'h00_0006_0000, 1'b0, 1'b0, 8'd6, 8'd4, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd1},
    '{2'd1, 40'hFD_F800_0000, 1'b1, 1'b1, 8'd4, 8'd7, 2'd2, 1'b0, 1'b1, 32'hF800_0000, 1'b0, 3'd0},
    '{2'd1, 40'hFD_F8FF_FFFC, 1'b1, 1'b1, 8'd4, 8'd7, 2'd2, 1'b0, 1'b1, 32'hF8FF_FFFC, 1'b0, 3'd0},
    '{2'd1, 40'hFD_F810_0000, 1'b1, 1'b0, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd4},
    '{2'd2, 40'hFD_F840_0000, 1'b1, 1'b1, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd3},
    '{2'd1, 40'hFD_F900_0000, 1'b1, 1'b1, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd5},
    '{2'd1, 40'hFD_F7FF_FFFC, 1'b1, 1'b1, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd5},
    '{2'd3, 40'h00_1000_0000, 1'b1, 1'b0, 8'd4, 8'd7, 2'd0, 1'b0, 1'b0, 32'h0,         1'b1, 3'd5},
    '{2'd0, 40'hFD_F805_1A14, 1'b0, 1'b0, 8'd4, 8'd7, 2'd1, 1'b1, 1'b0, 32'h0005_1A15, 1'b0, 3'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_kind_i = '0;
  logic [39:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_bcast_i = 1'b0;
  logic [7:0]  sec_bus_i = '0;
  logic [7:0]  sub_bus_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [1:0]  out_target_o;
  logic        out_type1_o;
  logic        out_write_o;
  logic [31:0] out_addr_o;
  logic        out_reject_o;
  logic [2:0]  out_reason_o;

  int n_run = 0;
  int n_fail = 0;
  string tags [NV];

  always #4 clk_i = ~clk_i;

  cfg_req_router dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_kind_i, .req_addr_i,
    .req_write_i, .req_bcast_i, .sec_bus_i, .sub_bus_i, .out_valid_o,
    .out_ready_i, .out_target_o, .out_type1_o, .out_write_o, .out_addr_o,
    .out_reject_o, .out_reason_o
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_out();
    return {24'h0, out_valid_o, out_target_o, out_type1_o, out_write_o,
            out_addr_o, out_reject_o, out_reason_o};
  endfunction

  function automatic logic [63:0] pack_exp(input vec_t v);
    return {24'h0, 1'b1, v.tgt, v.t1, v.ew, v.eaddr, v.rej, v.rsn};
  endfunction

  task automatic drive(input vec_t v);
    req_valid_i = 1'b1;
    req_kind_i  = v.kind;
    req_addr_i  = v.addr;
    req_write_i = v.wr;
    req_bcast_i = v.bc;
    sec_bus_i   = v.sec;
    sub_bus_i   = v.sub;
  endtask

  initial begin
    tags = '{"R2", "R2 R6", "R2", "R5", "R3", "R3 R6", "R4", "R4", "R4", "R2",
             "R4", "R7", "R7", "R8", "R8", "R9", "R9", "R9", "R3"};
    // R11: reset state
    #1;
    check("R11 valid in reset", {63'h0, out_valid_o}, 64'h0);
    check("R11 ready in reset", {63'h0, req_ready_o}, 64'h1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 valid after reset", {63'h0, out_valid_o}, 64'h0);

    // table walk, one vector per cycle, R10 covered by reject rows
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      check($sformatf("%s R10 vec%0d", tags[i], i), pack_out(), pack_exp(VECS[i]));
    end
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1 drains when idle", {63'h0, out_valid_o}, 64'h0);

    // R1: stall holds output, second request waits
    out_ready_i = 1'b0;
    drive(VECS[4]);
    @(negedge clk_i);
    check("R1 first taken", pack_out(), pack_exp(VECS[4]));
    check("R1 ready low on stall", {63'h0, req_ready_o}, 64'h0);
    drive(VECS[11]);
    repeat (3) @(negedge clk_i);
    check("R1 held during stall", pack_out(), pack_exp(VECS[4]));
    check("R1 still not ready", {63'h0, req_ready_o}, 64'h0);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    check("R1 second after release", pack_out(), pack_exp(VECS[11]));
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1 empty after drain", {63'h0, out_valid_o}, 64'h0);

    // R11: asynchronous reset mid-stream
    drive(VECS[0]);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R11 async clear", {63'h0, out_valid_o}, 64'h0);
    req_valid_i = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule